// File: doc/BRIEF.md
# Low-Transition Intermediate Pattern Sequencer

This block sits beside a two-phase 12-bit pseudorandom pattern generator built from four 3-bit fields. Its task is to cut switching activity in the circuit under test. For every generator step it emits four patterns instead of one, and the three extra patterns change far fewer bits than a direct jump between generator states.

A four-state controller issues a 4-bit control code every clock. The code is written as the group-A enable, the group-B enable, the group-A select and the group-B select. Group B is the top cell of each field (positions 2, 5, 8, 11). Group A is every other position. The two enables go out to the generator, so only one half of its cells advances in a given cycle. The two selects steer a per-position 2-to-1 choice. Each position shows either the generator bit or an inserted bit, and the inserted bit comes from an internal free-running LFSR.

Before a pattern leaves the block, fields 0 and 1 are exchanged, but only at the positions that currently show generator bits. The pattern is registered and is flagged by a valid strobe.

Top module: `lt_pattern_seq`

## Requirements
- R1: After reset the sequencer is idle. `pat_vld` is 0, `pat_out` is all zeros, both enables are 0, and the controller holds code 1011. It stays idle until `start` is sampled high on a rising clock edge.
- R2: Once running, the code steps every clock through 1011, 0010, 0111, 0001 and then back to 1011. The code bits are, from MSB to LSB: group-A enable, group-B enable, group-A select, group-B select. `grp_a_en` equals bit 3 and `grp_b_en` equals bit 2, so the two are never high together.
- R3: In code 1011, the pre-swap pattern equals `gen_bits`. Output positions 0,1,2 then carry pre-swap bits 3,4,5, and positions 3,4,5 carry bits 0,1,2.
- R4: In code 0111, the pattern is built exactly as in code 1011: all positions take the generator bit, and field 0 is exchanged with field 1.
- R5: In code 0010, group-A positions take the generator bit, and positions 0,1 are exchanged with positions 3,4. Group-B positions 2,5,8,11 take inserted bits and are not exchanged.
- R6: In code 0001, group-B positions take the generator bit, and position 2 is exchanged with position 5. Group-A positions take inserted bits and are not exchanged.
- R7: An inserted bit at a position is the random bit for that position only when the generator bit there differs from the value the position held just before its group last advanced. Otherwise the generator bit passes through unchanged. This history is all zeros after reset.
- R8: The random source is a 16-bit register `l` loaded with parameter `RND_SEED` (default 16'hACE1) at reset. On every clock edge while running it becomes {l[14:0], l[15]^l[13]^l[12]^l[10]}. Position i uses l[i] of the value held before that edge.
- R9: The pattern for the code present at a clock edge appears on `pat_out` after that edge. `pat_vld` goes high on the edge after the one that samples `start`, and then stays high, giving one pattern per code.
- R10: A `start` pulse while already running has no effect: the code sequence carries on without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins pattern production when sampled high |
| gen_bits | input | 12 | Current state of the external generator |
| grp_a_en | output | 1 | Advance enable for generator group A |
| grp_b_en | output | 1 | Advance enable for generator group B |
| pat_out | output | 12 | Registered test pattern |
| pat_vld | output | 1 | High while `pat_out` carries a produced pattern |

## Verification
The hardest condition to reach from the ports is an inserted bit that depends on history. It requires a generator position whose last group advance really flipped it, and an LFSR bit at that moment that disagrees with the generator bit. The bench therefore models the generator on its own: it obeys the block's two enables and advances only the enabled half, so the history the sequencer keeps reflects real half-advances. The bench then runs hundreds of cycles from a seed that makes the first insertion compare against the all-zero reset history. A second start pulse in mid-run and a reset in mid-run, followed by a restart, exercise the idle and restart paths.

// File: rtl/ltp_pkg.sv
package ltp_pkg;

   // Control code, written as {group-A enable, group-B enable, group-A select, group-B select}
   typedef enum logic [3:0] {
      CODE_FULL_A = 4'b1011,
      CODE_INS_B  = 4'b0010,
      CODE_FULL_B = 4'b0111,
      CODE_INS_A  = 4'b0001
   } code_e;

   function automatic code_e code_next(input code_e cur);
      code_e nxt;
      case (cur)
         CODE_FULL_A: nxt = CODE_INS_B;
         CODE_INS_B:  nxt = CODE_FULL_B;
         CODE_FULL_B: nxt = CODE_INS_A;
         default:     nxt = CODE_FULL_A;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/ltp_code_fsm.sv
module ltp_code_fsm
   import ltp_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   output code_e code,
   output logic  run
);

   code_e code_q;
   logic  run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         code_q <= CODE_FULL_A;
      end else begin
         if (start)
            run_q <= 1'b1;
         if (run_q)
            code_q <= code_next(code_q);
      end
   end

   assign code = code_q;
   assign run  = run_q;

   // R1: while idle the controller parks on the first code
   p_idle_park_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> code_q == CODE_FULL_A);

   // R2: the last code of the round wraps to the first
   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && code_q == CODE_INS_A) |=> code_q == CODE_FULL_A);

   // R10: running never drops back to idle without reset
   p_run_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> run_q);

endmodule

// File: rtl/ltp_rnd_src.sv
module ltp_rnd_src #(
   parameter int unsigned          RND_W    = 16,
   parameter logic [RND_W-1:0]     RND_TAPS = 16'hB400,
   parameter logic [RND_W-1:0]     RND_SEED = 16'hACE1,
   parameter int unsigned          OUT_W    = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [OUT_W-1:0] rnd
);

   generate
      if (RND_SEED == '0) begin : g_bad_seed
         $error("ltp_rnd_src: seed must be nonzero");
      end
      if (!RND_TAPS[RND_W-1]) begin : g_bad_taps
         $error("ltp_rnd_src: top tap must be set");
      end
      if (OUT_W > RND_W) begin : g_bad_width
         $error("ltp_rnd_src: output wider than register");
      end
   endgenerate

   logic [RND_W-1:0] lfsr_q;
   logic             fb;

   assign fb = ^(lfsr_q & RND_TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lfsr_q <= RND_SEED;
      else if (adv)
         lfsr_q <= {lfsr_q[RND_W-2:0], fb};
   end

   assign rnd = lfsr_q[OUT_W-1:0];

   // R8: the random register never locks up in the all-zero state
   p_rnd_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);

endmodule

// File: rtl/ltp_mix_swap.sv
module ltp_mix_swap #(
   parameter int unsigned FIELD_W = 3,
   parameter int unsigned FIELDS  = 4,
   localparam int unsigned PAT_W  = FIELD_W * FIELDS
) (
   input  logic [PAT_W-1:0] gen,
   input  logic [PAT_W-1:0] hist,
   input  logic [PAT_W-1:0] rnd,
   input  logic             sel_a,
   input  logic             sel_b,
   output logic [PAT_W-1:0] pat
);

   logic [PAT_W-1:0] take_gen;
   logic [PAT_W-1:0] mixed;

   for (genvar i = 0; i < PAT_W; i++) begin : g_mix
      localparam bit IS_B = ((i % FIELD_W) == FIELD_W - 1);
      if (IS_B) begin : g_b
         assign take_gen[i] = sel_b;
      end else begin : g_a
         assign take_gen[i] = sel_a;
      end
      assign mixed[i] = take_gen[i]          ? gen[i] :
                        (gen[i] != hist[i])  ? rnd[i] : gen[i];
   end

   // Field 0 and field 1 trade places wherever the generator bit is shown
   for (genvar i = 0; i < PAT_W; i++) begin : g_swap
      localparam int unsigned FLD = i / FIELD_W;
      if (FLD == 0) begin : g_f0
         assign pat[i] = take_gen[i] ? mixed[i + FIELD_W] : mixed[i];
      end else if (FLD == 1) begin : g_f1
         assign pat[i] = take_gen[i] ? mixed[i - FIELD_W] : mixed[i];
      end else begin : g_fn
         assign pat[i] = mixed[i];
      end
   end

endmodule

// File: rtl/lt_pattern_seq.sv
module lt_pattern_seq
   import ltp_pkg::*;
#(
   parameter int unsigned      FIELD_W  = 3,
   parameter int unsigned      FIELDS   = 4,
   parameter int unsigned      RND_W    = 16,
   parameter logic [RND_W-1:0] RND_TAPS = 16'hB400,
   parameter logic [RND_W-1:0] RND_SEED = 16'hACE1,
   localparam int unsigned     PAT_W    = FIELD_W * FIELDS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PAT_W-1:0] gen_bits,
   output logic             grp_a_en,
   output logic             grp_b_en,
   output logic [PAT_W-1:0] pat_out,
   output logic             pat_vld
);

   generate
      if (FIELD_W < 2) begin : g_bad_field
         $error("lt_pattern_seq: fields need at least two cells");
      end
      if (FIELDS < 2) begin : g_bad_fields
         $error("lt_pattern_seq: at least two fields are needed for the swap");
      end
      if (RND_W < PAT_W) begin : g_bad_rnd
         $error("lt_pattern_seq: random register narrower than pattern");
      end
   endgenerate

   code_e            code;
   logic             run;
   logic [3:0]       code_bits;
   logic             sel_a;
   logic             sel_b;
   logic [PAT_W-1:0] rnd;
   logic [PAT_W-1:0] hist_q;
   logic [PAT_W-1:0] grp_b_mask;
   logic [PAT_W-1:0] next_pat;
   logic [PAT_W-1:0] pat_q;
   logic             vld_q;

   ltp_code_fsm u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .code  (code),
      .run   (run)
   );

   assign code_bits = code;
   assign grp_a_en  = run & code_bits[3];
   assign grp_b_en  = run & code_bits[2];
   assign sel_a     = code_bits[1];
   assign sel_b     = code_bits[0];

   ltp_rnd_src #(
      .RND_W    (RND_W),
      .RND_TAPS (RND_TAPS),
      .RND_SEED (RND_SEED),
      .OUT_W    (PAT_W)
   ) u_rnd (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (run),
      .rnd   (rnd)
   );

   // History: each position keeps the value it had before its group last advanced
   for (genvar i = 0; i < PAT_W; i++) begin : g_hist
      localparam bit IS_B = ((i % FIELD_W) == FIELD_W - 1);
      logic upd;
      if (IS_B) begin : g_b
         assign upd = grp_b_en;
         assign grp_b_mask[i] = 1'b1;
      end else begin : g_a
         assign upd = grp_a_en;
         assign grp_b_mask[i] = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hist_q[i] <= 1'b0;
         else if (upd)
            hist_q[i] <= gen_bits[i];
      end
   end

   ltp_mix_swap #(
      .FIELD_W (FIELD_W),
      .FIELDS  (FIELDS)
   ) u_mix (
      .gen   (gen_bits),
      .hist  (hist_q),
      .rnd   (rnd),
      .sel_a (sel_a),
      .sel_b (sel_b),
      .pat   (next_pat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= run;
         if (run)
            pat_q <= next_pat;
      end
   end

   assign pat_out = pat_q;
   assign pat_vld = vld_q;

   // R2: the two generator halves never advance together
   p_en_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(grp_a_en && grp_b_en));

   // R2: a group-B advance follows two cycles after a group-A advance
   p_b_after_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(grp_a_en, 2) |-> grp_b_en);

   // R7: group-A history only moves on a group-A advance
   p_hist_a_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_a_en |=> $stable(hist_q & ~grp_b_mask));

   // R9: once patterns flow they flow every cycle
   p_vld_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pat_vld |=> pat_vld);

endmodule

// File: tb/test_lt_pattern_seq.sv
`timescale 1ns/100ps
module test_lt_pattern_seq;

   localparam int PW = 12;
   localparam logic [11:0] B_MASK = 12'h924;
   localparam logic [11:0] A_MASK = 12'h6DB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [PW-1:0] gen_bits = 12'hFFF;
   logic          grp_a_en, grp_b_en, pat_vld;
   logic [PW-1:0] pat_out;

   lt_pattern_seq i_lt_pattern_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .gen_bits (gen_bits),
      .grp_a_en (grp_a_en),
      .grp_b_en (grp_b_en),
      .pat_out  (pat_out),
      .pat_vld  (pat_vld)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [13:0] exp_q[$];

   bit         m_run, m_vld;
   int         m_idx;
   logic [11:0] m_hist;
   logic [15:0] m_rnd;

   function automatic logic [11:0] gen_step(input logic [11:0] g);
      return {g[10:0], g[11] ^ g[10] ^ g[9] ^ g[3]};
   endfunction

   function automatic logic [15:0] rnd_step(input logic [15:0] r);
      return {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
   endfunction

   function automatic logic [11:0] expect_pat(input int idx, input logic [11:0] g,
                                              input logic [11:0] h, input logic [15:0] r);
      logic [11:0] x, y, shown;
      for (int i = 0; i < 12; i++) begin
         bit is_b = ((i % 3) == 2);
         shown[i] = (idx == 0) || (idx == 2) || (idx == 1 && !is_b) || (idx == 3 && is_b);
         x[i] = shown[i] ? g[i] : ((g[i] != h[i]) ? r[i] : g[i]);
      end
      y = x;
      for (int k = 0; k < 3; k++) begin
         if (shown[k]) begin
            y[k]     = x[k + 3];
            y[k + 3] = x[k];
         end
      end
      return y;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      m_run = 1'b0; m_vld = 1'b0; m_idx = 0;
      m_hist = '0; m_rnd = 16'hACE1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      start = 1'b0;
      exp_q.delete();
      model_clear();
      gen_bits = 12'hFFF;
      repeat (3) @(negedge clk);
      check(pat_vld == 1'b0, "R1 valid after reset", {15'd0, pat_vld}, 16'd0);
      check(pat_out == '0, "R1 pattern after reset", {4'd0, pat_out}, 16'd0);
      check({grp_a_en, grp_b_en} == 2'b00, "R1 enables after reset",
            {14'd0, grp_a_en, grp_b_en}, 16'd0);
      rst_n = 1'b1;
   endtask

   task automatic cycle(input bit st);
      logic [11:0] g_n, h_n;
      logic [15:0] r_n;
      int idx_n;
      bit exp_a, exp_b;
      @(negedge clk);
      start = st;
      check(pat_vld == m_vld, "R9 valid strobe", {15'd0, pat_vld}, {15'd0, m_vld});
      exp_a = m_run && (m_idx == 0);
      exp_b = m_run && (m_idx == 2);
      check({grp_a_en, grp_b_en} == {exp_a, exp_b}, "R2 R10 enable code",
            {14'd0, grp_a_en, grp_b_en}, {14'd0, exp_a, exp_b});
      g_n = gen_bits; h_n = m_hist; r_n = m_rnd; idx_n = m_idx;
      if (m_run) begin
         logic [1:0] idx2;
         idx2 = 2'(m_idx);
         exp_q.push_back({idx2, expect_pat(m_idx, gen_bits, m_hist, m_rnd)});
         if (m_idx == 0) begin
            g_n = (gen_step(gen_bits) & A_MASK) | (gen_bits & B_MASK);
            h_n = (m_hist & B_MASK) | (gen_bits & A_MASK);
         end else if (m_idx == 2) begin
            g_n = (gen_step(gen_bits) & B_MASK) | (gen_bits & A_MASK);
            h_n = (m_hist & A_MASK) | (gen_bits & B_MASK);
         end
         r_n = rnd_step(m_rnd);
         idx_n = (m_idx + 1) % 4;
      end
      @(posedge clk);
      #1;
      gen_bits = g_n;
      m_hist = h_n;
      m_rnd = r_n;
      m_vld = m_run;
      m_idx = idx_n;
      m_run = m_run | st;
   endtask

   // Monitor: pops expected patterns as the design presents them
   always @(negedge clk) begin
      if (rst_n && pat_vld && !done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9 pattern without expectation", {4'd0, pat_out}, 16'd0);
         end else begin
            logic [13:0] e;
            string tag;
            e = exp_q.pop_front();
            case (e[13:12])
               2'd0:    tag = "R3 R8 code 1011 pattern";
               2'd1:    tag = "R5 R7 R8 code 0010 pattern";
               2'd2:    tag = "R4 R8 code 0111 pattern";
               default: tag = "R6 R7 R8 code 0001 pattern";
            endcase
            check(pat_out == e[11:0], tag, {4'd0, pat_out}, {4'd0, e[11:0]});
         end
      end
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_clear();
      do_reset();
      repeat (6) cycle(1'b0);          // R1: idle without start
      cycle(1'b1);
      repeat (150) cycle(1'b0);
      cycle(1'b1);                     // R10: start while running
      repeat (101) cycle(1'b0);
      do_reset();
      repeat (3) cycle(1'b0);
      cycle(1'b1);
      repeat (122) cycle(1'b0);
      @(negedge clk);
      #1;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule